// File: doc/BRIEF.md
# AXI Response Expectation Checker

This block checks each read or write response that comes back from an AXI subordinate against the response that the issuing command said it should get. Every command carries a 3-bit expectation code. The top bit of that code says whether the code names an explicit expected response. When the top bit is clear, the expected response is worked out from the lock setting of the access. An exclusive access should get EXOKAY, and any other access should get OKAY.

The block has one read lane and one write lane. They share the error bookkeeping. A read burst is judged only on its final beat. A write is judged on every valid response. A mismatch raises a one-cycle error pulse on its lane and sets a sticky error flag, which holds until a clear input removes it. A mismatch also adds to a saturating error counter. Responses are assumed to arrive in order, with their command's expectation code and lock value already attached, so no ID tracking is done here.

Top module: `axi_resp_checker`

## Requirements
- R1: When bit 2 of an expectation code is 1, the expected response is bits [1:0] of that code. So 3'b100 expects OKAY (2'b00), 3'b101 expects EXOKAY (2'b01), 3'b110 expects SLVERR (2'b10) and 3'b111 expects DECERR (2'b11).
- R2: When bit 2 of an expectation code is 0, the expected response is inferred from the lock input. A lock value of 2'b01 (exclusive) expects EXOKAY (2'b01). Lock values 2'b00, 2'b10 and 2'b11 expect OKAY (2'b00). Bits [1:0] of the code are then ignored.
- R3: A read response is checked only when `rd_valid` and `rd_last` are both 1. A beat with `rd_last` = 0 never raises an error, whatever its response value.
- R4: A write response is checked on every cycle in which `wr_valid` is 1.
- R5: A checked response that differs from its expected value makes that lane's error output (`rd_err` or `wr_err`) 1 for exactly one cycle, after the clock edge that samples the response. A matching response leaves the error output at 0.
- R6: `err_flag` becomes 1 at the edge that samples any mismatch. It stays 1 until an edge that samples `clr` = 1 with no new mismatch in the same cycle. When `clr` and a mismatch come in the same cycle, the flag ends up 1.
- R7: `err_count` grows by the number of mismatches sampled at an edge (0, 1 or 2, counting both lanes). It saturates at 65535 and never wraps. `clr` does not change it.
- R8: While `rst_n` is 0, `rd_err`, `wr_err`, `err_flag` and `err_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Clears the sticky error flag |
| rd_valid | input | 1 | A read response beat is present |
| rd_last | input | 1 | The beat is the final beat of its burst |
| rd_resp | input | 2 | Read response value (AXI encoding) |
| rd_exp | input | 3 | Expectation code of the read command |
| rd_lock | input | 2 | Lock setting of the read command |
| wr_valid | input | 1 | A write response is present |
| wr_resp | input | 2 | Write response value (AXI encoding) |
| wr_exp | input | 3 | Expectation code of the write command |
| wr_lock | input | 2 | Lock setting of the write command |
| rd_err | output | 1 | One-cycle pulse on a read mismatch |
| wr_err | output | 1 | One-cycle pulse on a write mismatch |
| err_flag | output | 1 | Sticky error flag |
| err_count | output | CNT_W (16) | Saturating mismatch count |

## Verification
All results of a response are due at the same rising edge, the one that samples that response. The lane pulse, the sticky flag and the counter each have exactly one register stage. The pulse must then drop at the next edge unless another mismatch arrives. The bench changes inputs on the falling edge and reads the outputs 2 ns after the following rising edge. It compares them with a model in the bench that it updates from the same stimulus in the same step, so each check looks at exactly the edge where the result is due.

// File: rtl/axi_resp_chk_pkg.sv
package axi_resp_chk_pkg;

  typedef logic [1:0] resp_t;
  typedef logic [2:0] exp_code_t;
  typedef logic [1:0] lock_t;

  localparam resp_t RESP_OKAY   = 2'b00;
  localparam resp_t RESP_EXOKAY = 2'b01;
  localparam resp_t RESP_SLVERR = 2'b10;
  localparam resp_t RESP_DECERR = 2'b11;

  localparam lock_t LOCK_EXCLUSIVE = 2'b01;

  // Expected response: an explicit code when bit 2 is set, else inferred from lock.
  function automatic resp_t expected_resp(input exp_code_t code, input lock_t lock);
    if (code[2]) begin
      return code[1:0];
    end
    return (lock == LOCK_EXCLUSIVE) ? RESP_EXOKAY : RESP_OKAY;
  endfunction

  // True when a sampled response disagrees with its expectation.
  function automatic logic resp_mismatch(input resp_t resp, input exp_code_t code,
                                         input lock_t lock);
    return resp != expected_resp(code, lock);
  endfunction

endpackage

// File: rtl/resp_chk_lane.sv
module resp_chk_lane
  import axi_resp_chk_pkg::*;
#(
  parameter int USE_LAST = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      valid,
  input  logic      last,
  input  resp_t     resp,
  input  exp_code_t exp_code,
  input  lock_t     lock,
  output logic      hit,
  output logic      err_q
);

  localparam logic LAST_DONTCARE = (USE_LAST == 0);

  logic take;

  assign take = valid & (last | LAST_DONTCARE);
  assign hit  = take & resp_mismatch(resp, exp_code, lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= hit;
    end
  end

endmodule

// File: rtl/resp_chk_sat_cnt.sv
module resp_chk_sat_cnt #(
  parameter int W    = 16,
  parameter int N_IN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] inc_vec,
  output logic [W-1:0]    count
);

  localparam int         INC_W   = $clog2(N_IN + 1);
  localparam logic [W:0] MAX_EXT = {1'b0, {W{1'b1}}};

  function automatic logic [INC_W-1:0] pop(input logic [N_IN-1:0] v);
    logic [INC_W-1:0] n;
    n = '0;
    for (int i = 0; i < N_IN; i++) begin
      n = n + INC_W'(v[i]);
    end
    return n;
  endfunction

  logic [W:0]   sum;
  logic [W-1:0] nxt;

  always_comb begin
    sum = {1'b0, count} + (W + 1)'(pop(inc_vec));
    nxt = (sum > MAX_EXT) ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= nxt;
    end
  end

endmodule

// File: rtl/resp_chk_sticky.sv
module resp_chk_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_any,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set_any) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/axi_resp_checker.sv
module axi_resp_checker
  import axi_resp_chk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rd_valid,
  input  logic             rd_last,
  input  logic [1:0]       rd_resp,
  input  logic [2:0]       rd_exp,
  input  logic [1:0]       rd_lock,
  input  logic             wr_valid,
  input  logic [1:0]       wr_resp,
  input  logic [2:0]       wr_exp,
  input  logic [1:0]       wr_lock,
  output logic             rd_err,
  output logic             wr_err,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_count
);

  localparam int NUM_LANES = 2;
  localparam int LANE_RD   = 0;
  localparam int LANE_WR   = 1;

  logic      l_valid [NUM_LANES];
  logic      l_last  [NUM_LANES];
  resp_t     l_resp  [NUM_LANES];
  exp_code_t l_exp   [NUM_LANES];
  lock_t     l_lock  [NUM_LANES];
  logic [NUM_LANES-1:0] l_hit;
  logic [NUM_LANES-1:0] l_err;

  // Named events for the assertions.
  logic rd_hit;
  logic wr_hit;
  logic any_hit;

  assign l_valid[LANE_RD] = rd_valid;
  assign l_last[LANE_RD]  = rd_last;
  assign l_resp[LANE_RD]  = rd_resp;
  assign l_exp[LANE_RD]   = rd_exp;
  assign l_lock[LANE_RD]  = rd_lock;

  assign l_valid[LANE_WR] = wr_valid;
  assign l_last[LANE_WR]  = 1'b1;
  assign l_resp[LANE_WR]  = wr_resp;
  assign l_exp[LANE_WR]   = wr_exp;
  assign l_lock[LANE_WR]  = wr_lock;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    resp_chk_lane #(
      .USE_LAST((g == LANE_RD) ? 1 : 0)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (l_valid[g]),
      .last     (l_last[g]),
      .resp     (l_resp[g]),
      .exp_code (l_exp[g]),
      .lock     (l_lock[g]),
      .hit      (l_hit[g]),
      .err_q    (l_err[g])
    );
  end

  assign rd_hit  = l_hit[LANE_RD];
  assign wr_hit  = l_hit[LANE_WR];
  assign any_hit = |l_hit;

  assign rd_err = l_err[LANE_RD];
  assign wr_err = l_err[LANE_WR];

  resp_chk_sticky u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .set_any (any_hit),
    .flag    (err_flag)
  );

  resp_chk_sat_cnt #(
    .W    (CNT_W),
    .N_IN (NUM_LANES)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_vec (l_hit),
    .count   (err_count)
  );

endmodule

// File: rtl/axi_resp_checker_sva.sv
module axi_resp_checker_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             rd_valid,
  input logic             rd_last,
  input logic [1:0]       rd_resp,
  input logic [2:0]       rd_exp,
  input logic             wr_valid,
  input logic [1:0]       wr_resp,
  input logic [2:0]       wr_exp,
  input logic [1:0]       wr_lock,
  input logic             rd_hit,
  input logic             wr_hit,
  input logic             rd_err,
  input logic             wr_err,
  input logic             err_flag,
  input logic [CNT_W-1:0] err_count
);

  // R1: explicit expectation differing from the read response gives a pulse
  a_r1_explicit_rd_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_last && rd_exp[2] && (rd_resp != rd_exp[1:0])) |=> rd_err);

  // R2: an exclusive write answered OKAY under inferred mode is an error
  a_r2_excl_okay_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_exp[2] && (wr_lock == 2'b01) && (wr_resp == 2'b00)) |=> wr_err);

  // R3: a read pulse only follows a final beat
  a_r3_last_only: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(rd_valid && rd_last));

  // R4: a write pulse only follows a valid write response
  a_r4_write_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid));

  // R5: each lane event becomes a registered pulse one edge later
  a_r5_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rd_err);
  a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> wr_err);

  // R6: sticky flag accompanies every pulse and drops only after clear
  a_r6_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err || wr_err) |-> err_flag);
  a_r6_fall_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(clr));

  // R7: counter never decreases and stays at its ceiling
  a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count >= $past(err_count)));
  a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (&err_count) |=> (&err_count));

endmodule

bind axi_resp_checker axi_resp_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .rd_valid  (rd_valid),
  .rd_last   (rd_last),
  .rd_resp   (rd_resp),
  .rd_exp    (rd_exp),
  .wr_valid  (wr_valid),
  .wr_resp   (wr_resp),
  .wr_exp    (wr_exp),
  .wr_lock   (wr_lock),
  .rd_hit    (rd_hit),
  .wr_hit    (wr_hit),
  .rd_err    (rd_err),
  .wr_err    (wr_err),
  .err_flag  (err_flag),
  .err_count (err_count)
);

// File: tb/axi_resp_checker_bench.sv
`timescale 1ns/1ps
module axi_resp_checker_bench;

  localparam int CNT_MAX = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        rd_valid = 1'b0, rd_last = 1'b0;
  logic [1:0]  rd_resp = '0, rd_lock = '0;
  logic [2:0]  rd_exp = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_resp = '0, wr_lock = '0;
  logic [2:0]  wr_exp = '0;
  logic        rd_err, wr_err, err_flag;
  logic [15:0] err_count;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  bit m_flag = 1'b0;

  always #10 clk = ~clk;

  axi_resp_checker u_axi_resp_checker (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_resp(rd_resp),
    .rd_exp(rd_exp), .rd_lock(rd_lock),
    .wr_valid(wr_valid), .wr_resp(wr_resp), .wr_exp(wr_exp), .wr_lock(wr_lock),
    .rd_err(rd_err), .wr_err(wr_err), .err_flag(err_flag), .err_count(err_count)
  );

  function automatic logic [1:0] ref_exp(input logic [2:0] c, input logic [1:0] k);
    case (c)
      3'b100:  return 2'd0;
      3'b101:  return 2'd1;
      3'b110:  return 2'd2;
      3'b111:  return 2'd3;
      default: return (k == 2'b01) ? 2'd1 : 2'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, update the model, check at the sampling edge.
  task automatic apply(input string tag,
                       input logic rv, input logic rl, input logic [1:0] rr,
                       input logic [2:0] re, input logic [1:0] rk,
                       input logic wv, input logic [1:0] wr, input logic [2:0] we,
                       input logic [1:0] wk, input logic cl, input bit chk);
    bit er, ew;
    @(negedge clk);
    rd_valid = rv; rd_last = rl; rd_resp = rr; rd_exp = re; rd_lock = rk;
    wr_valid = wv; wr_resp = wr; wr_exp = we; wr_lock = wk; clr = cl;
    er = rv && rl && (rr != ref_exp(re, rk));
    ew = wv && (wr != ref_exp(we, wk));
    m_cnt = m_cnt + int'(er) + int'(ew);
    if (m_cnt > CNT_MAX) m_cnt = CNT_MAX;
    if (er || ew) m_flag = 1'b1;
    else if (cl) m_flag = 1'b0;
    @(posedge clk);
    #2;
    if (chk) begin
      check(tag, "rd_err", int'(rd_err), int'(er));
      check(tag, "wr_err", int'(wr_err), int'(ew));
      check(tag, "err_flag", int'(err_flag), int'(m_flag));
      check(tag, "err_count", int'(err_count), m_cnt);
    end
  endtask

  task automatic idle(input string tag);
    apply(tag, 0, 0, 2'd0, 3'd0, 2'd0, 0, 2'd0, 3'd0, 2'd0, 0, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R8", "rd_err", int'(rd_err), 0);
    check("R8", "wr_err", int'(wr_err), 0);
    check("R8", "err_flag", int'(err_flag), 0);
    check("R8", "err_count", int'(err_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_explicit_write();
    for (int c = 4; c < 8; c++) begin
      for (int r = 0; r < 4; r++) begin
        apply("R1", 0, 0, 2'd0, 3'd0, 2'd0, 1, 2'(r), 3'(c), 2'(r), 0, 1);
        idle("R5");
      end
    end
  endtask

  task automatic t_inferred_read();
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 4; k++) begin
        for (int r = 0; r < 2; r++) begin
          apply("R2", 1, 1, 2'(r), 3'(c), 2'(k), 0, 2'd0, 3'd0, 2'd0, 0, 1);
        end
      end
    end
    idle("R2");
  endtask

  task automatic t_read_last();
    apply("R3", 1, 0, 2'd3, 3'b100, 2'd0, 0, 2'd0, 3'd0, 2'd0, 0, 1);
    apply("R3", 1, 0, 2'd2, 3'b000, 2'd1, 0, 2'd0, 3'd0, 2'd0, 0, 1);
    apply("R3", 1, 1, 2'd2, 3'b100, 2'd0, 0, 2'd0, 3'd0, 2'd0, 0, 1);
    apply("R4", 0, 0, 2'd0, 3'd0, 2'd0, 1, 2'd1, 3'b000, 2'd0, 0, 1);
    apply("R4", 0, 0, 2'd0, 3'd0, 2'd0, 0, 2'd3, 3'b100, 2'd0, 0, 1);
    idle("R5");
  endtask

  task automatic t_sticky();
    apply("R6", 0, 0, 2'd0, 3'd0, 2'd0, 0, 2'd0, 3'd0, 2'd0, 1, 1);
    idle("R6");
    apply("R6", 1, 1, 2'd3, 3'b101, 2'd0, 0, 2'd0, 3'd0, 2'd0, 1, 1);
    idle("R6");
    apply("R6", 0, 0, 2'd0, 3'd0, 2'd0, 0, 2'd0, 3'd0, 2'd0, 1, 1);
    apply("R6", 0, 0, 2'd0, 3'd0, 2'd0, 1, 2'd0, 3'b100, 2'd0, 0, 1);
    idle("R6");
  endtask

  task automatic t_dual();
    apply("R7", 1, 1, 2'd1, 3'b110, 2'd0, 1, 2'd2, 3'b111, 2'd0, 0, 1);
    apply("R7", 1, 1, 2'd0, 3'b000, 2'd0, 1, 2'd2, 3'b000, 2'd1, 1, 1);
    idle("R7");
  endtask

  task automatic t_saturate();
    while (m_cnt < CNT_MAX - 3) begin
      apply("R7", 1, 1, 2'd3, 3'b100, 2'd0, 1, 2'd3, 3'b100, 2'd0, 0, 0);
    end
    if (m_cnt != CNT_MAX - 3) begin
      apply("R7", 0, 0, 2'd0, 3'd0, 2'd0, 1, 2'd3, 3'b100, 2'd0, 0, 1);
    end
    idle("R7");
    apply("R7", 1, 1, 2'd3, 3'b100, 2'd0, 1, 2'd3, 3'b100, 2'd0, 0, 1);
    apply("R7", 1, 1, 2'd3, 3'b100, 2'd0, 1, 2'd3, 3'b100, 2'd0, 0, 1);
    apply("R7", 1, 1, 2'd3, 3'b100, 2'd0, 1, 2'd3, 3'b100, 2'd0, 1, 1);
    idle("R7");
    check("R7", "saturated", int'(err_count), CNT_MAX);
  endtask

  initial begin
    t_reset();
    t_explicit_write();
    t_inferred_read();
    t_read_last();
    t_sticky();
    t_dual();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule